// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Modes

This block is a small bank of one-bit storage entries, eight by default, selected by a binary address. Two active-low control inputs pick one of four behaviours. The block can write a single addressed entry, hold every entry, steer the data bit to the addressed output line only, or clear the whole bank. It is a clocked stand-in for a transparent latch array. Writes and clears are registered on the rising clock edge through an internal write strobe and clear strobe. The output bus is chosen combinationally, so the steering and clearing views follow the inputs at once.

A typical use is to set individual control bits one at a time from a narrow data path and keep them parked. The same part can instead act as a gated one-hot decoder without disturbing what is stored. Because an address that flips several bits at once may briefly point at the wrong entry, the address should be moved only while the bank is holding.

Top module: `addr_bit_latch`

## Requirements
- R1: The control pair {hold_ni, clear_ni} selects the mode as follows: 2'b01 is write, 2'b11 is hold, 2'b00 is steer and 2'b10 is clear.
- R2: In write mode, the entry named by sel_i takes din_i on the rising clock edge. From that edge on, q_o shows the new value at bit sel_i.
- R3: In write mode, every entry other than the addressed one keeps its previous value.
- R4: In hold mode, the stored entries and q_o do not change, whatever sel_i and din_i do.
- R5: In steer mode, q_o[sel_i] equals din_i and every other bit of q_o is 0. This output is combinational, with no clock delay.
- R6: Steer mode neither writes nor clears storage. After it ends, q_o again shows the contents stored before steer mode began.
- R7: In clear mode, q_o is all zeros at once, whatever sel_i and din_i are.
- R8: Clear mode zeroes every stored entry on the rising clock edge, so all entries read 0 after a return to hold mode.
- R9: sel_i is plain binary with bit 0 least significant, and a value n addresses q_o[n]. Outputs are non-inverting: a stored or steered 1 appears as 1.
- R10: An asynchronous low on rst_ni clears every stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes and clears land on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of storage |
| din_i | input | 1 | Data bit to store or steer |
| sel_i | input | ADDR_W | Binary entry address, bit 0 least significant |
| hold_ni | input | 1 | Active-low enable: low writes or steers, high holds or clears |
| clear_ni | input | 1 | Active-low clear: low steers or clears, high writes or holds |
| q_o | output | 2**ADDR_W | Parallel output bus, one bit per entry |

## Verification
The bench builds the block with the default address width of three, which gives eight entries. With that width, every address can be driven in every mode, both by directed sweeps and by thousands of random cycles. The small bank lets a bench model track every stored bit exactly, so each cycle's output can be checked. This covers the hidden contents during steer mode and their return afterwards, clears issued from any mode, and an asynchronous reset in the middle of a run.

// File: rtl/addr_bit_latch_pkg.sv
package addr_bit_latch_pkg;

    // Mode encoding is {hold_n, clear_n}
    typedef enum logic [1:0] {
        MODE_STEER = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;

    typedef struct packed {
        logic wr_stb;     // store din into addressed entry at edge
        logic clr_stb;    // zero all entries at edge
        logic show_steer; // output is decoded data bit
        logic show_zero;  // output forced low
    } ctrl_t;

endpackage

// File: rtl/addr_bit_latch_mode_dec.sv
module addr_bit_latch_mode_dec
    import addr_bit_latch_pkg::*;
(
    input  logic  hold_ni,
    input  logic  clear_ni,
    output ctrl_t ctrl_o
);
    mode_e mode;

    always_comb begin
        mode   = mode_e'({hold_ni, clear_ni});
        ctrl_o = '0;
        unique case (mode)
            MODE_WRITE: ctrl_o.wr_stb = 1'b1;
            MODE_HOLD:  ctrl_o = '0;
            MODE_STEER: ctrl_o.show_steer = 1'b1;
            MODE_CLEAR: begin
                ctrl_o.clr_stb   = 1'b1;
                ctrl_o.show_zero = 1'b1;
            end
            default:    ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/addr_bit_latch_onehot.sv
module addr_bit_latch_onehot #(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel_i,
    output logic [N-1:0]      hot_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign hot_o[g] = (sel_i == ADDR_W'(g));
    end
endmodule

// File: rtl/addr_bit_latch_store.sv
module addr_bit_latch_store #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_stb_i,
    input  logic         clr_stb_i,
    input  logic [N-1:0] hot_i,
    input  logic         din_i,
    output logic [N-1:0] bits_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_stb_i) begin
            st_d.bits = '0;
        end else if (wr_stb_i) begin
            st_d.bits = (st_q.bits & ~hot_i) | (hot_i & {N{din_i}});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
    import addr_bit_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              din_i,
    input  logic [ADDR_W-1:0] sel_i,
    input  logic              hold_ni,
    input  logic              clear_ni,
    output logic [N-1:0]      q_o
);
    ctrl_t        ctrl;
    logic [N-1:0] hot;
    logic [N-1:0] stored;

    addr_bit_latch_mode_dec u_mode (
        .hold_ni (hold_ni),
        .clear_ni(clear_ni),
        .ctrl_o  (ctrl)
    );

    addr_bit_latch_onehot #(.ADDR_W(ADDR_W)) u_hot (
        .sel_i(sel_i),
        .hot_o(hot)
    );

    addr_bit_latch_store #(.N(N)) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_stb_i (ctrl.wr_stb),
        .clr_stb_i(ctrl.clr_stb),
        .hot_i    (hot),
        .din_i    (din_i),
        .bits_o   (stored)
    );

    for (genvar g = 0; g < N; g++) begin : g_out
        always_comb begin
            if (ctrl.show_zero) begin
                q_o[g] = 1'b0;
            end else if (ctrl.show_steer) begin
                q_o[g] = hot[g] & din_i;
            end else begin
                q_o[g] = stored[g];
            end
        end
    end
endmodule

// File: rtl/addr_bit_latch_chk.sv
module addr_bit_latch_chk #(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              din_i,
    input logic [ADDR_W-1:0] sel_i,
    input logic              hold_ni,
    input logic              clear_ni,
    input logic [N-1:0]      q_o
);
    logic m_write, m_hold, m_steer, m_clear;
    assign m_write = !hold_ni &&  clear_ni;
    assign m_hold  =  hold_ni &&  clear_ni;
    assign m_steer = !hold_ni && !clear_ni;
    assign m_clear =  hold_ni && !clear_ni;

    assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_write |=> (m_hold -> q_o[$past(sel_i)] == $past(din_i)));

    assert_hold_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_hold |=> (m_hold -> $stable(q_o)));

    assert_steer_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_steer |-> ($countones(q_o) == int'(din_i) && q_o[sel_i] == din_i));

    assert_clear_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_clear |-> q_o == '0);

    assert_clear_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_clear |=> (m_hold -> q_o == '0));
endmodule

bind addr_bit_latch addr_bit_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (din_i),
    .sel_i   (sel_i),
    .hold_ni (hold_ni),
    .clear_ni(clear_ni),
    .q_o     (q_o)
);

// File: tb/addr_bit_latch_tb_top.sv
module addr_bit_latch_tb_top;
    localparam int ADDR_W = 3;
    localparam int N = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] sel = '0;
    logic              hold_n = 1'b1;
    logic              clear_n = 1'b1;
    logic [N-1:0]      q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N-1:0] model = '0;

    always #2 clk = ~clk;

    addr_bit_latch #(.ADDR_W(ADDR_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .din_i(din), .sel_i(sel),
        .hold_ni(hold_n), .clear_ni(clear_n), .q_o(q)
    );

    function automatic logic [N-1:0] exp_out(logic hn, logic cn, logic d,
                                             logic [ADDR_W-1:0] a, logic [N-1:0] m);
        if (hn && !cn) return '0;                              // R7
        if (!hn && !cn) return d ? (N'(1) << a) : '0;          // R5 R9
        return m;                                              // R4 R6
    endfunction

    function automatic logic [N-1:0] next_model(logic hn, logic cn, logic d,
                                                logic [ADDR_W-1:0] a, logic [N-1:0] m);
        logic [N-1:0] r = m;
        if (hn && !cn) r = '0;                                 // R8
        else if (!hn && cn) r[a] = d;                          // R2 R3
        return r;
    endfunction

    function automatic string req_of(logic hn, logic cn);
        if (hn && !cn) return "R7";
        if (!hn && !cn) return "R5";
        if (!hn && cn) return "R2 R3";
        return "R4 R6";
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q_o=%b expected %b", req, act, exp);
        end
    endtask

    // Drive one cycle: apply at negedge, compare before posedge, update model at posedge
    task automatic cycle(logic hn, logic cn, logic d, logic [ADDR_W-1:0] a, string req = "");
        @(negedge clk);
        hold_n = hn; clear_n = cn; din = d; sel = a;
        #1;
        check(req == "" ? req_of(hn, cn) : req, q, exp_out(hn, cn, d, a, model));
        @(posedge clk);
        model = next_model(hn, cn, d, a, model);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        #1;
        check("R10 reset", q, '0);
        #8;
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b1, 1'b1, 1'b1, 3'd5, "R10 hold after reset");
        // R1 R9: write alternating pattern through every address
        for (int i = 0; i < N; i++) cycle(1'b0, 1'b1, i[0], ADDR_W'(i), "R2 R9");
        cycle(1'b1, 1'b1, 1'b0, 3'd0, "R9 pattern");
        // R4: hold with busy address and data
        for (int i = 0; i < N; i++) cycle(1'b1, 1'b1, ~i[0], ADDR_W'(i), "R4");
        // R5 R9: steer each address with both data values
        for (int i = 0; i < N; i++) begin
            cycle(1'b0, 1'b0, 1'b1, ADDR_W'(i), "R5 R9");
            cycle(1'b0, 1'b0, 1'b0, ADDR_W'(i), "R5");
        end
        // R6: back to hold, prior contents reappear
        cycle(1'b1, 1'b1, 1'b0, 3'd3, "R6");
        cycle(1'b1, 1'b1, 1'b1, 3'd6, "R6");
        // R3: single write leaves neighbours
        cycle(1'b0, 1'b1, 1'b1, 3'd0, "R3");
        cycle(1'b1, 1'b1, 1'b0, 3'd0, "R3");
        // R7 R8: clear then hold
        cycle(1'b1, 1'b0, 1'b1, 3'd7, "R7");
        cycle(1'b1, 1'b1, 1'b1, 3'd7, "R8");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] mc = 2'($urandom());
            cycle(mc[1], mc[0], 1'($urandom()), ADDR_W'($urandom()));
        end
        // R10: async reset mid-run
        for (int i = 0; i < N; i++) cycle(1'b0, 1'b1, 1'b1, ADDR_W'(i), "R2");
        @(negedge clk);
        hold_n = 1'b1; clear_n = 1'b1;
        rst_n = 1'b0;
        #1;
        model = '0;
        check("R10 async", q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b1, 1'b1, 1'b1, 3'd2, "R10");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule